// File: doc/BRIEF.md
# Maintenance procedure launcher

This block gives host software a two-register window for launching numbered hardware maintenance procedures and polling them to completion. Software writes a procedure number into the control register. The block classifies the number and then does one of three things. It starts the matching executor engine, or it finishes the request at once, or it aborts the procedure that is running. Software then polls the status register until the completion flag rises, and reads the result code from it.

Ten executor engines sit behind the block, one for each real procedure from 4 to 13. Each engine receives a one-cycle start pulse and a one-cycle abort pulse. It answers with a done pulse and a 2-bit result. Procedure 5 is a one-time calibration: only the first request for it reaches its engine. The register port is plain and single-cycle. A write takes effect on the clock edge where it is sampled. A read is combinational from the address, so the port has no back-pressure.

Top module: `proc_ctl_regs`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) both read 0, and no start or abort pulse is driven. Status layout: bit 31 is busy, bit 30 is done, and bits 3:0 hold the result code.
- R2: Writing a number from 4 to 13 while idle has these effects on the next edge. The control register holds the number, the status register reads 0x8000_0000, and `exec_num` shows the number. A start pulse of exactly one cycle goes out on `exec_start` bit (number − 4).
- R3: A done pulse from the active executor ends the procedure. Bit 31 clears, bit 30 sets, and the code becomes the 2-bit result (0 success, 1 transient, 2 permanent). A done pulse from any other executor is ignored, and so is a done pulse while idle.
- R4: Writing a nonzero number while busy pulses `exec_abort` for the active executor, and the block then handles the new number as it would from idle. Writing a real number therefore also starts the new executor, and the status reads 0x8000_0000.
- R5: Writing 0 while busy aborts the running procedure. The status becomes 0x4000_0003 and the control register keeps the aborted number. Writing 0 while idle has no effect.
- R6: Writing 1 (no-op) completes at once. The status becomes 0x4000_0000, the control register reads 1, and no start pulse is issued.
- R7: Writing 2, 3, or any value above 13 completes at once as unsupported. The status becomes 0x4000_0004 and no start pulse is issued.
- R8: The first write of 5 starts executor bit 1. Every later write of 5 completes at once with status 0x4000_0000 and the control register reading 5, and no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on a rising edge |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Write data (procedure number) |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| exec_start | output | 10 | One-hot start pulse, bit i = procedure 4+i |
| exec_abort | output | 10 | One-hot abort pulse to the active executor |
| exec_num | output | 32 | Current procedure number |
| exec_done | input | 10 | Done pulse from each executor |
| exec_result | input | 2 | Result that goes with the done pulse |

## Verification
The hardest case to reach from the ports is an abort by overwrite. On that edge an abort pulse goes to one executor and a start pulse goes to another. A stray done from an executor that is not active must also leave the busy state untouched. The bench gets there by starting a procedure and leaving its executor silent. It then writes either a second real number or 0, and sends done pulses on the wrong executor line before it answers on the right one.

// File: rtl/proc_ctl_pkg.sv
package proc_ctl_pkg;
  typedef enum logic [1:0] {
    K_ABORT_ONLY,
    K_INSTANT_OK,
    K_UNSUPPORTED,
    K_LAUNCH
  } req_kind_e;

  localparam logic [3:0] CODE_OK     = 4'd0;
  localparam logic [3:0] CODE_ABORT  = 4'd3;
  localparam logic [3:0] CODE_UNSUPP = 4'd4;
endpackage

// File: rtl/proc_classify.sv
module proc_classify
  import proc_ctl_pkg::*;
#(
  parameter int DW       = 32,
  parameter int FIRST    = 4,
  parameter int LAST     = 13,
  parameter int NOP_NUM  = 1,
  parameter int ONCE_NUM = 5
) (
  input  logic [DW-1:0] num,
  input  logic          once_used,
  output req_kind_e     kind
);
  always_comb begin
    if (num == '0)
      kind = K_ABORT_ONLY;
    else if (num == DW'(NOP_NUM) || (num == DW'(ONCE_NUM) && once_used))
      kind = K_INSTANT_OK;
    else if (num >= DW'(FIRST) && num <= DW'(LAST))
      kind = K_LAUNCH;
    else
      kind = K_UNSUPPORTED;
  end
endmodule

// File: rtl/proc_onehot.sv
module proc_onehot #(
  parameter int DW    = 32,
  parameter int FIRST = 4,
  parameter int N     = 10
) (
  input  logic [DW-1:0] num,
  input  logic          en,
  output logic [N-1:0]  oh
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign oh[i] = en && (num == DW'(FIRST + i));
  end
endmodule

// File: rtl/proc_ctl_regs.sv
module proc_ctl_regs
  import proc_ctl_pkg::*;
#(
  parameter int FIRST    = 4,
  parameter int LAST     = 13,
  parameter int NOP_NUM  = 1,
  parameter int ONCE_NUM = 5,
  localparam int DW      = 32,
  localparam int N_EXEC  = LAST - FIRST + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [N_EXEC-1:0] exec_start,
  output logic [N_EXEC-1:0] exec_abort,
  output logic [DW-1:0]     exec_num,
  input  logic [N_EXEC-1:0] exec_done,
  input  logic [1:0]        exec_result
);
  logic          busy_q, done_q, once_used_q;
  logic [3:0]    code_q;
  logic [DW-1:0] cur_q;
  req_kind_e     kind;
  logic [N_EXEC-1:0] act_oh, new_oh;
  logic          wr_ctl, done_hit;

  assign wr_ctl = reg_wr && (reg_addr == 1'b0);

  proc_classify #(
    .DW(DW), .FIRST(FIRST), .LAST(LAST), .NOP_NUM(NOP_NUM), .ONCE_NUM(ONCE_NUM)
  ) u_classify (
    .num(reg_wdata), .once_used(once_used_q), .kind(kind)
  );

  proc_onehot #(.DW(DW), .FIRST(FIRST), .N(N_EXEC)) u_active (
    .num(cur_q), .en(busy_q), .oh(act_oh)
  );

  proc_onehot #(.DW(DW), .FIRST(FIRST), .N(N_EXEC)) u_launch (
    .num(reg_wdata), .en(wr_ctl && kind == K_LAUNCH), .oh(new_oh)
  );

  assign done_hit = busy_q && |(exec_done & act_oh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      once_used_q <= 1'b0;
      code_q      <= CODE_OK;
      cur_q       <= '0;
      exec_start  <= '0;
      exec_abort  <= '0;
    end else begin
      exec_start <= '0;
      exec_abort <= '0;
      if (wr_ctl) begin
        if (busy_q) exec_abort <= act_oh;
        unique case (kind)
          K_ABORT_ONLY: begin
            if (busy_q) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              code_q <= CODE_ABORT;
            end
          end
          K_INSTANT_OK: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            code_q <= CODE_OK;
            cur_q  <= reg_wdata;
          end
          K_UNSUPPORTED: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            code_q <= CODE_UNSUPP;
            cur_q  <= reg_wdata;
          end
          K_LAUNCH: begin
            busy_q     <= 1'b1;
            done_q     <= 1'b0;
            code_q     <= CODE_OK;
            cur_q      <= reg_wdata;
            exec_start <= new_oh;
            if (reg_wdata == DW'(ONCE_NUM)) once_used_q <= 1'b1;
          end
          default: ;
        endcase
      end else if (done_hit) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        code_q <= {2'b00, exec_result};
      end
    end
  end

  assign exec_num  = cur_q;
  assign reg_rdata = reg_addr ? {busy_q, done_q, 26'd0, code_q} : cur_q;
endmodule

// File: rtl/proc_ctl_regs_chk.sv
module proc_ctl_regs_chk #(
  parameter int FIRST    = 4,
  parameter int LAST     = 13,
  parameter int NOP_NUM  = 1,
  parameter int ONCE_NUM = 5,
  parameter int N        = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [N-1:0]  exec_start,
  input logic [N-1:0]  exec_abort,
  input logic          busy_q,
  input logic          done_q,
  input logic [3:0]    code_q,
  input logic [31:0]   cur_q
);
  localparam int ONCE_IDX = ONCE_NUM - FIRST;
  logic [1:0] once_starts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) once_starts <= '0;
    else if (exec_start[ONCE_IDX] && once_starts != 2'd3) once_starts <= once_starts + 2'd1;
  end

  // R2
  start_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|exec_start) |-> busy_q);

  // R2
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exec_start));

  // R3
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  // R4
  abort_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|exec_abort) |-> ($onehot(exec_abort) && $past(reg_wr && reg_addr == 1'b0)));

  // R7
  unsupp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && code_q == 4'd4) |->
      (cur_q != 32'(NOP_NUM) && (cur_q < 32'(FIRST) || cur_q > 32'(LAST))));

  // R8
  once_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    once_starts < 2'd2);
endmodule

bind proc_ctl_regs proc_ctl_regs_chk #(
  .FIRST(FIRST), .LAST(LAST), .NOP_NUM(NOP_NUM), .ONCE_NUM(ONCE_NUM), .N(N_EXEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .exec_start(exec_start), .exec_abort(exec_abort),
  .busy_q(busy_q), .done_q(done_q), .code_q(code_q), .cur_q(cur_q)
);

// File: tb/tb_proc_ctl_regs.sv
module tb_proc_ctl_regs;
  localparam int N = 10;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_addr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  exec_start, exec_abort;
  logic [31:0]   exec_num;
  logic [N-1:0]  exec_done = '0;
  logic [1:0]    exec_result = '0;
  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  proc_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exec_start(exec_start),
    .exec_abort(exec_abort), .exec_num(exec_num), .exec_done(exec_done),
    .exec_result(exec_result)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr_ctl(input logic [31:0] num);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = num;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic give_done(input int idx, input logic [1:0] res);
    @(negedge clk);
    exec_done = '0; exec_done[idx] = 1'b1; exec_result = res;
    @(negedge clk);
    exec_done = '0;
  endtask

  task automatic expect_regs(input string req, input logic [31:0] ctl, input logic [31:0] st);
    logic [31:0] v;
    rd(1'b0, v); check(req, "control", v, ctl);
    rd(1'b1, v); check(req, "status", v, st);
  endtask

  task automatic t_reset;
    expect_regs("R1", 32'h0, 32'h0);
    check("R1", "start", 32'(exec_start), 32'h0);
    check("R1", "abort", 32'(exec_abort), 32'h0);
  endtask

  task automatic t_run;
    wr_ctl(6);
    check("R2", "start", 32'(exec_start), 32'h4);
    check("R2", "num", exec_num, 32'd6);
    expect_regs("R2", 32'd6, 32'h8000_0000);
    @(negedge clk);
    check("R2", "start one cycle", 32'(exec_start), 32'h0);
    give_done(0, 2'd2);
    expect_regs("R3", 32'd6, 32'h8000_0000);
    give_done(2, 2'd1);
    expect_regs("R3", 32'd6, 32'h4000_0001);
    give_done(2, 2'd2);
    expect_regs("R3", 32'd6, 32'h4000_0001);
  endtask

  task automatic t_overwrite;
    wr_ctl(9);
    check("R4", "first start", 32'(exec_start), 32'h20);
    wr_ctl(10);
    check("R4", "abort", 32'(exec_abort), 32'h20);
    check("R4", "start", 32'(exec_start), 32'h40);
    expect_regs("R4", 32'd10, 32'h8000_0000);
    give_done(5, 2'd2);
    expect_regs("R4", 32'd10, 32'h8000_0000);
    give_done(6, 2'd0);
    expect_regs("R3", 32'd10, 32'h4000_0000);
  endtask

  task automatic t_abort_zero;
    wr_ctl(7);
    wr_ctl(0);
    check("R5", "abort", 32'(exec_abort), 32'h8);
    check("R5", "start", 32'(exec_start), 32'h0);
    expect_regs("R5", 32'd7, 32'h4000_0003);
    wr_ctl(0);
    check("R5", "idle abort", 32'(exec_abort), 32'h0);
    expect_regs("R5", 32'd7, 32'h4000_0003);
  endtask

  task automatic t_nop;
    wr_ctl(1);
    check("R6", "start", 32'(exec_start), 32'h0);
    expect_regs("R6", 32'd1, 32'h4000_0000);
  endtask

  task automatic t_unsupported;
    wr_ctl(2);
    check("R7", "start", 32'(exec_start), 32'h0);
    expect_regs("R7", 32'd2, 32'h4000_0004);
    wr_ctl(1);
    wr_ctl(3);
    expect_regs("R7", 32'd3, 32'h4000_0004);
    wr_ctl(1);
    wr_ctl(14);
    check("R7", "start 14", 32'(exec_start), 32'h0);
    expect_regs("R7", 32'd14, 32'h4000_0004);
    wr_ctl(32'hFFFF_FFFF);
    expect_regs("R7", 32'hFFFF_FFFF, 32'h4000_0004);
    wr_ctl(13);
    check("R2", "start 13", 32'(exec_start), 32'h200);
    give_done(9, 2'd2);
    expect_regs("R3", 32'd13, 32'h4000_0002);
  endtask

  task automatic t_once;
    wr_ctl(5);
    check("R8", "first start", 32'(exec_start), 32'h2);
    give_done(1, 2'd0);
    expect_regs("R8", 32'd5, 32'h4000_0000);
    wr_ctl(2);
    wr_ctl(5);
    check("R8", "repeat start", 32'(exec_start), 32'h0);
    expect_regs("R8", 32'd5, 32'h4000_0000);
    @(negedge clk);
    check("R8", "repeat start late", 32'(exec_start), 32'h0);
  endtask

  initial begin
    #1_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run();
    t_overwrite();
    t_abort_zero();
    t_nop();
    t_unsupported();
    t_once();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule